// File: doc/BRIEF.md
# Flash Command Sequencer

This block is the command front end of a small embedded flash store. A processor-style byte bus issues write cycles carrying command codes. The sequencer decodes one-cycle and two-cycle command sequences, runs program and erase jobs against an internal byte array, and keeps an 8-bit status register with a ready flag and sticky error flags. Each bus read returns one of two sources, selected by the current read mode: an array byte at the bus address, or the status register.

Program and erase jobs take a fixed number of clock cycles, set by a parameter. While a job runs, the ready output is low and every bus write is dropped. When a job starts, the sequencer switches to status reads on its own, so a polling loop sees the ready bit rise and can then check the error flags. Commands are accepted only while the rewrite enable input is high.

Top module: `flash_cmd_seq`

## Requirements
- R1: After synchronous reset, ready is 1, the read mode is array, every array byte reads 0xFF, and the status register reads 0x80.
- R2: A write of 0xFF selects array reads. Each later read returns the byte at bus_addr, and this mode holds until another accepted command changes it.
- R3: A write of 0x70 selects status reads. The status byte is laid out as follows: bit 7 is ready, bit 5 is the erase/sequence error flag, bit 4 is the program error flag, bit 1 is a further error flag that this block never sets, and all other bits read 0.
- R4: A write of 0x50 clears bits 5, 4 and 1 of the status register in one cycle. It leaves the read mode unchanged.
- R5: A write of 0x40 arms programming. The next accepted write supplies the address and data and starts a job that stores old AND data at that address. On that start cycle the block switches to status reads. The address given with a first-cycle command has no effect.
- R6: After the write edge that starts a job, ready and status bit 7 stay 0 for exactly BUSY_CYCLES cycles, then both return to 1.
- R7: When a program job completes and the stored byte differs from the requested data, status bit 4 is set. It stays set until a 0x50 command.
- R8: The sequence 0x20 then 0x20 erases the whole array to 0xFF when the job completes.
- R9: The sequence 0x20 then 0xD0 erases one block of 2^BLK_W bytes to 0xFF. The block is the one that contains the second-cycle address, selected by the upper ADDR_W-BLK_W address bits. All other bytes are left unchanged.
- R10: If any byte other than 0x20 or 0xD0 follows 0x20, status bits 5 and 4 are set, the block switches to status reads, and no job starts, so ready stays 1.
- R11: Bus writes that arrive while ready is 0 have no effect on the mode, the armed command or the array.
- R12: Writes while rewrite_en is 0 have no effect. A first-cycle byte that is not a known command code has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rewrite_en | input | 1 | Enables command acceptance |
| bus_we | input | 1 | Bus write strobe, sampled on the clock edge |
| bus_addr | input | ADDR_W | Byte address for reads and second-cycle writes |
| bus_wdata | input | 8 | Command code or program data |
| bus_rdata | output | 8 | Array byte or status register, per read mode |
| ready | output | 1 | 1 when idle, 0 while a job runs |

## Verification
bus_rdata is a combinational mux. It reflects a mode change or a status update one clock edge after the write that causes it, and it follows a new bus_addr within the same cycle. Ready falls on the edge that takes the second command byte and rises on the edge BUSY_CYCLES later. Array contents and status bit 4 change on that same later edge. The bench drives on falling edges and samples just after a falling edge. It checks ready at the first and last busy cycles and on the cycle after them. Array contents are read only after ready has returned and array mode has been selected again.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    typedef enum logic {
        MODE_ARRAY,
        MODE_STATUS
    } rd_mode_e;

    typedef enum logic [1:0] {
        PEND_NONE,
        PEND_PROG,
        PEND_ERASE
    } pend_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_PROG,
        OP_ERASE_ALL,
        OP_ERASE_BLK
    } op_e;

    typedef struct packed {
        logic sr5;
        logic sr4;
        logic sr1;
    } err_t;

    localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;
    localparam logic [7:0] CMD_READ_STATUS = 8'h70;
    localparam logic [7:0] CMD_CLEAR_ERR   = 8'h50;
    localparam logic [7:0] CMD_PROGRAM     = 8'h40;
    localparam logic [7:0] CMD_ERASE       = 8'h20;
    localparam logic [7:0] CMD_ERASE_BLK   = 8'hD0;

    function automatic logic [7:0] pack_status(input logic busy, input err_t e);
        return {~busy, 1'b0, e.sr5, e.sr4, 2'b00, e.sr1, 1'b0};
    endfunction

endpackage

// File: rtl/fcs_busy_timer.sv
module fcs_busy_timer #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CW'(CYCLES);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CW'(1));

endmodule

// File: rtl/fcs_array.sv
module fcs_array
    import fcs_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BLK_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  op_e               op,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [7:0]        op_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              verify_fail
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0]       mem [DEPTH];
    logic [DEPTH-1:0] wipe;

    // Per-byte erase hit: whole array, or the addressed block only.
    for (genvar g = 0; g < DEPTH; g++) begin : g_wipe
        localparam logic [ADDR_W-1:0] IDX = ADDR_W'(g);
        assign wipe[g] = (op == OP_ERASE_ALL) ||
                         ((op == OP_ERASE_BLK) &&
                          (IDX[ADDR_W-1:BLK_W] == op_addr[ADDR_W-1:BLK_W]));
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst || wipe[i]) begin
                mem[i] <= 8'hFF;
            end else if ((op == OP_PROG) && (op_addr == ADDR_W'(i))) begin
                mem[i] <= mem[i] & op_data;
            end
        end
    end

    assign rd_data     = mem[rd_addr];
    // Cells only move toward 0: the result differs when data needs a 0->1.
    assign verify_fail = ((mem[op_addr] & op_data) != op_data);

endmodule

// File: rtl/fcs_ctrl.sv
module fcs_ctrl
    import fcs_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rewrite_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              busy,
    input  logic              done,
    input  logic              verify_fail,
    output rd_mode_e          mode,
    output pend_e             pend,
    output err_t              err,
    output logic              start,
    output op_e               apply_op,
    output logic [ADDR_W-1:0] job_addr,
    output logic [7:0]        job_data
);
    op_e  job_op;
    logic accept;
    logic erase_ok;

    assign accept   = bus_we && rewrite_en && !busy;
    assign erase_ok = (bus_wdata == CMD_ERASE) || (bus_wdata == CMD_ERASE_BLK);
    assign start    = accept && ((pend == PEND_PROG) || ((pend == PEND_ERASE) && erase_ok));
    assign apply_op = done ? job_op : OP_NONE;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= MODE_ARRAY;
            pend     <= PEND_NONE;
            err      <= '0;
            job_op   <= OP_NONE;
            job_addr <= '0;
            job_data <= '0;
        end else begin
            if (done && (job_op == OP_PROG) && verify_fail) begin
                err.sr4 <= 1'b1;
            end
            if (accept) begin
                unique case (pend)
                    PEND_PROG: begin
                        job_op   <= OP_PROG;
                        job_addr <= bus_addr;
                        job_data <= bus_wdata;
                        mode     <= MODE_STATUS;
                        pend     <= PEND_NONE;
                    end
                    PEND_ERASE: begin
                        mode     <= MODE_STATUS;
                        pend     <= PEND_NONE;
                        job_addr <= bus_addr;
                        if (bus_wdata == CMD_ERASE) begin
                            job_op <= OP_ERASE_ALL;
                        end else if (bus_wdata == CMD_ERASE_BLK) begin
                            job_op <= OP_ERASE_BLK;
                        end else begin
                            err.sr4 <= 1'b1;
                            err.sr5 <= 1'b1;
                        end
                    end
                    default: begin
                        unique case (bus_wdata)
                            CMD_READ_ARRAY:  mode <= MODE_ARRAY;
                            CMD_READ_STATUS: mode <= MODE_STATUS;
                            CMD_CLEAR_ERR:   err  <= '0;
                            CMD_PROGRAM:     pend <= PEND_PROG;
                            CMD_ERASE:       pend <= PEND_ERASE;
                            default: ;
                        endcase
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int BLK_W       = 4,
    parameter int BUSY_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rewrite_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              ready
);
    rd_mode_e          rd_mode;
    pend_e             pend;
    err_t              err_flags;
    logic              job_start;
    logic              tmr_busy;
    logic              tmr_done;
    logic              verify_fail;
    op_e               apply_op;
    logic [ADDR_W-1:0] job_addr;
    logic [7:0]        job_data;
    logic [7:0]        arr_rdata;

    fcs_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .rewrite_en (rewrite_en),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .busy       (tmr_busy),
        .done       (tmr_done),
        .verify_fail(verify_fail),
        .mode       (rd_mode),
        .pend       (pend),
        .err        (err_flags),
        .start      (job_start),
        .apply_op   (apply_op),
        .job_addr   (job_addr),
        .job_data   (job_data)
    );

    fcs_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .start(job_start),
        .busy (tmr_busy),
        .done (tmr_done)
    );

    fcs_array #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_array (
        .clk        (clk),
        .rst        (rst),
        .op         (apply_op),
        .op_addr    (job_addr),
        .op_data    (job_data),
        .rd_addr    (bus_addr),
        .rd_data    (arr_rdata),
        .verify_fail(verify_fail)
    );

    assign bus_rdata = (rd_mode == MODE_STATUS) ? pack_status(tmr_busy, err_flags) : arr_rdata;
    assign ready     = ~tmr_busy;

endmodule

// File: rtl/fcs_checker.sv
module fcs_checker
    import fcs_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       rewrite_en,
    input logic       bus_we,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       ready,
    input rd_mode_e   mode,
    input pend_e      pend,
    input err_t       err,
    input logic       start
);
    // R1: leaving reset gives an idle block in array mode
    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ready && mode == MODE_ARRAY && err == '0));

    // R3: status reads carry the ready flag in bit 7
    p_status_ready_bit_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_STATUS) |-> (bus_rdata[7] == ready));

    // R5: a starting job switches to status reads
    p_auto_status_r5: assert property (@(posedge clk) disable iff (rst)
        start |=> (mode == MODE_STATUS));

    // R6: a starting job drops ready on the next cycle
    p_start_busy_r6: assert property (@(posedge clk) disable iff (rst)
        start |=> !ready);

    // R10: bad second erase byte flags errors and starts nothing
    p_seq_error_r10: assert property (@(posedge clk) disable iff (rst)
        (rewrite_en && bus_we && ready && pend == PEND_ERASE &&
         bus_wdata != CMD_ERASE && bus_wdata != CMD_ERASE_BLK)
        |=> (err.sr4 && err.sr5 && ready && mode == MODE_STATUS));

    // R11: writes during a job leave mode and armed command alone
    p_busy_ignore_r11: assert property (@(posedge clk) disable iff (rst)
        (!ready && bus_we) |=> ($stable(mode) && $stable(pend)));

    // R12: disabled bus writes leave mode and armed command alone
    p_disabled_ignore_r12: assert property (@(posedge clk) disable iff (rst)
        (!rewrite_en) |=> ($stable(mode) && $stable(pend)));

endmodule

bind flash_cmd_seq fcs_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .rewrite_en(rewrite_en),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ready     (ready),
    .mode      (rd_mode),
    .pend      (pend),
    .err       (err_flags),
    .start     (job_start)
);

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 6;
    localparam int BUSY       = 8;
    localparam int NV         = 49;

    // Vector: {req[3:0], kind[1:0], addr[7:0], data[7:0], expected[7:0]}
    // kind 0 = write data, 1 = read and compare, 2 = wait for ready
    localparam logic [29:0] VEC [NV] = '{
        {4'd1,  2'd1, 8'h00, 8'h00, 8'hFF},  // R1 erased array after reset
        {4'd3,  2'd0, 8'h00, 8'h70, 8'h00},
        {4'd3,  2'd1, 8'h00, 8'h00, 8'h80},  // R3 status after reset
        {4'd5,  2'd0, 8'h3F, 8'h40, 8'h00},  // R5 first-cycle address ignored
        {4'd5,  2'd0, 8'h05, 8'hA5, 8'h00},
        {4'd6,  2'd2, 8'h00, 8'h00, 8'h00},  // R6
        {4'd5,  2'd1, 8'h00, 8'h00, 8'h80},  // R5 status mode, no error
        {4'd2,  2'd0, 8'h00, 8'hFF, 8'h00},
        {4'd5,  2'd1, 8'h05, 8'h00, 8'hA5},  // R5 programmed byte
        {4'd2,  2'd1, 8'h06, 8'h00, 8'hFF},  // R2 neighbour untouched
        {4'd7,  2'd0, 8'h00, 8'h40, 8'h00},
        {4'd7,  2'd0, 8'h05, 8'h5A, 8'h00},
        {4'd6,  2'd2, 8'h00, 8'h00, 8'h00},
        {4'd7,  2'd1, 8'h00, 8'h00, 8'h90},  // R7 program error flag
        {4'd2,  2'd0, 8'h00, 8'hFF, 8'h00},
        {4'd2,  2'd1, 8'h05, 8'h00, 8'h00},  // R2 AND result
        {4'd4,  2'd0, 8'h00, 8'h50, 8'h00},
        {4'd4,  2'd1, 8'h05, 8'h00, 8'h00},  // R4 mode kept
        {4'd4,  2'd0, 8'h00, 8'h70, 8'h00},
        {4'd4,  2'd1, 8'h00, 8'h00, 8'h80},  // R4 flags cleared
        {4'd10, 2'd0, 8'h00, 8'h20, 8'h00},
        {4'd10, 2'd0, 8'h00, 8'h33, 8'h00},
        {4'd10, 2'd1, 8'h00, 8'h00, 8'hB0},  // R10 sequence error
        {4'd4,  2'd0, 8'h00, 8'h50, 8'h00},
        {4'd4,  2'd1, 8'h00, 8'h00, 8'h80},  // R4
        {4'd5,  2'd0, 8'h00, 8'h40, 8'h00},
        {4'd5,  2'd0, 8'h12, 8'h0F, 8'h00},
        {4'd6,  2'd2, 8'h00, 8'h00, 8'h00},
        {4'd5,  2'd0, 8'h00, 8'h40, 8'h00},
        {4'd5,  2'd0, 8'h25, 8'hF0, 8'h00},
        {4'd6,  2'd2, 8'h00, 8'h00, 8'h00},
        {4'd2,  2'd0, 8'h00, 8'hFF, 8'h00},
        {4'd5,  2'd1, 8'h12, 8'h00, 8'h0F},  // R5
        {4'd5,  2'd1, 8'h25, 8'h00, 8'hF0},  // R5
        {4'd9,  2'd0, 8'h00, 8'h20, 8'h00},
        {4'd9,  2'd0, 8'h1F, 8'hD0, 8'h00},
        {4'd6,  2'd2, 8'h00, 8'h00, 8'h00},
        {4'd2,  2'd0, 8'h00, 8'hFF, 8'h00},
        {4'd9,  2'd1, 8'h12, 8'h00, 8'hFF},  // R9 block 1 erased
        {4'd9,  2'd1, 8'h25, 8'h00, 8'hF0},  // R9 block 2 kept
        {4'd9,  2'd1, 8'h05, 8'h00, 8'h00},  // R9 block 0 kept
        {4'd8,  2'd0, 8'h00, 8'h20, 8'h00},
        {4'd8,  2'd0, 8'h00, 8'h20, 8'h00},
        {4'd6,  2'd2, 8'h00, 8'h00, 8'h00},
        {4'd2,  2'd0, 8'h00, 8'hFF, 8'h00},
        {4'd8,  2'd1, 8'h25, 8'h00, 8'hFF},  // R8
        {4'd8,  2'd1, 8'h05, 8'h00, 8'hFF},  // R8
        {4'd12, 2'd0, 8'h00, 8'h11, 8'h00},
        {4'd12, 2'd1, 8'h05, 8'h00, 8'hFF}   // R12 unknown code ignored
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rewrite_en = 1'b1;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic          ready;
    logic [29:0]   v;
    int            n_checks = 0;
    int            n_fails  = 0;

    flash_cmd_seq #(.ADDR_W(AW), .BLK_W(4), .BUSY_CYCLES(BUSY)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .rewrite_en(rewrite_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ready     (ready)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input string req, input logic [AW-1:0] a, input logic [7:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic wait_ready(input string req);
        int spins = 0;
        while (!ready && spins < 4 * BUSY) begin
            @(negedge clk);
            spins++;
        end
        #1;
        check(req, {7'd0, ready}, 8'h01);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        do_reset();
        #1;
        check("R1 ready after reset", {7'd0, ready}, 8'h01);

        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            case (v[25:24])
                2'd0: wr(v[16+AW-1:16], v[15:8]);
                2'd1: begin
                    @(negedge clk);
                    bus_addr = v[16+AW-1:16];
                    #1;
                    n_checks++;
                    if (bus_rdata !== v[7:0]) begin
                        n_fails++;
                        $display("FAIL R%0d vector %0d: actual %h expected %h",
                                 v[29:26], i, bus_rdata, v[7:0]);
                    end
                end
                default: wait_ready("R6 job completes");
            endcase
        end

        // R6: busy window length, measured from the start edge
        wr(6'h00, 8'h40);
        wr(6'h03, 8'h00);
        check("R6 ready low first busy cycle", {7'd0, ready}, 8'h00);
        repeat (BUSY - 1) @(negedge clk);
        #1;
        check("R6 ready low last busy cycle", {7'd0, ready}, 8'h00);
        check("R6 status bit7 low while busy", {7'd0, bus_rdata[7]}, 8'h00);
        @(negedge clk);
        #1;
        check("R6 ready back after window", {7'd0, ready}, 8'h01);
        check("R6 status after window", bus_rdata, 8'h80);

        // R11: writes during a job change nothing
        wr(6'h00, 8'h40);
        wr(6'h07, 8'h00);
        wr(6'h00, 8'hFF);
        wr(6'h00, 8'h40);
        wr(6'h08, 8'h00);
        wait_ready("R11 job completes");
        rd("R11 still status mode", 6'h08, 8'h80);
        wr(6'h00, 8'hFF);
        rd("R11 armed program applied", 6'h07, 8'h00);
        rd("R11 busy-time program ignored", 6'h08, 8'hFF);

        // R12: disabled bus writes change nothing
        rewrite_en = 1'b0;
        wr(6'h00, 8'h70);
        wr(6'h00, 8'h20);
        wr(6'h00, 8'h20);
        #1;
        check("R12 no job when disabled", {7'd0, ready}, 8'h01);
        rd("R12 still array mode", 6'h03, 8'h00);
        rewrite_en = 1'b1;

        // R1: reset from a programmed, status-mode state
        wr(6'h00, 8'h70);
        do_reset();
        #1;
        check("R1 ready after second reset", {7'd0, ready}, 8'h01);
        rd("R1 array mode and erased byte", 6'h07, 8'hFF);
        wr(6'h00, 8'h70);
        rd("R1 status value after reset", 6'h00, 8'h80);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule